// File: doc/BRIEF.md
# Receive Inactivity Timeout Counter

This block is a down-counting timer meant to sit beside a UART receive channel. It has two modes. In normal mode a start command loads a preload value and the counter steps down once per tick enable. A stop command halts it. Each time the count runs out, a sticky ready flag is raised.

In timeout mode the start and stop commands have no effect. Instead, the receiver's character-transfer pulse reloads and restarts the counter. A transfer pulse is raised each time a character moves from the shift register into the holding register. While characters keep arriving, the count never reaches zero. A raised ready flag therefore marks a gap in the incoming data.

Entering timeout mode halts the counter and clears the flag. The counter then stays idle until the first character arrives. Leaving timeout mode hands control back to the start and stop commands, and leaves both the count and the flag as they were.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `ready` is 0, `count` is 0, the counter is halted and the block is in normal mode.
- R2: In normal mode, a `cmd_start` pulse loads `preload` into `count` on the next clock edge and starts the counter. While the counter runs, each cycle with `tick` high lowers `count` by one. `count` can be read at any time.
- R3: A tick that finds `count` equal to 1 does three things on that edge: it sets `ready`, it reloads `count` from `preload`, and it leaves the counter running. `ready` then stays at 1 until a command clears it.
- R4: In normal mode, a `cmd_stop` pulse halts the counter and clears `ready`. Ticks that follow leave `count` unchanged.
- R5: A `cmd_tmo_on` pulse enters timeout mode, halts the counter and clears `ready`. `count` keeps its value through any number of ticks until the first `rx_xfer` pulse.
- R6: While timeout mode is on, `cmd_start` and `cmd_stop` are ignored. They neither load, halt nor clear anything.
- R7: While timeout mode is on, an `rx_xfer` pulse reloads `count` from `preload` and starts the counter; it does not change `ready`. In normal mode, `rx_xfer` has no effect.
- R8: A `cmd_tmo_off` pulse returns to normal mode. It does not halt a running counter and does not clear `ready`. From the next cycle on, `cmd_start` and `cmd_stop` work again.
- R9: In normal mode after timeout mode has been turned off, `cmd_stop` clears a pending `ready`.
- R10: Priority within one cycle:
  - `cmd_tmo_on` overrides every other input.
  - A load, from `cmd_start` in normal mode or `rx_xfer` in timeout mode, overrides a tick and overrides `cmd_stop`.
  - The mode used to decode the commands in a cycle is the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preload | input | CNT_W | Value loaded on start, on a receive transfer, and on each expiry |
| tick | input | 1 | Count enable, one decrement per cycle while running |
| cmd_start | input | 1 | Start pulse (normal mode only) |
| cmd_stop | input | 1 | Stop pulse; halts and clears ready (normal mode only) |
| cmd_tmo_on | input | 1 | Enter timeout mode |
| cmd_tmo_off | input | 1 | Leave timeout mode |
| rx_xfer | input | 1 | Receiver character-transfer pulse |
| ready | output | 1 | Sticky expiry flag |
| count | output | CNT_W | Current count |

## Verification
The in-line assertions check these rules on every cycle:
- Entering timeout mode clears `ready` on the next cycle.
- A receive transfer in timeout mode loads the preload value.
- A start command in timeout mode leaves the count untouched.
- Leaving timeout mode preserves a set flag.
- A normal-mode stop clears the flag.
- `ready` can only rise after a tick that found the count at 1.

Some behaviour shows only over a sequence of events, so the bench's directed scenarios are what demonstrate it:
- The idle wait after arming, across many ticks, until the first character.
- The wrap-around reload that keeps the counter running after it expires.
- A stop that is ignored in timeout mode but takes effect once the mode is off.
- `rx_xfer` having no effect in normal mode.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  // Action the mode controller requests from the counter in one cycle.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,  // count on tick if running
    OP_LOAD = 2'd1,  // load preload and run
    OP_HALT = 2'd2,  // stop running, clear ready
    OP_ARM  = 2'd3   // enter timeout mode: stop, clear ready, wait for data
  } rxt_op_e;
endpackage

// File: rtl/rxt_mode_ctrl.sv
module rxt_mode_ctrl
  import rxt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_start,
  input  logic    cmd_stop,
  input  logic    cmd_tmo_on,
  input  logic    cmd_tmo_off,
  input  logic    rx_xfer,
  output rxt_op_e op,
  output logic    tmo_mode
);
  // Mode register: arming has priority over disarming.
  always_ff @(posedge clk) begin
    if (rst)              tmo_mode <= 1'b0;
    else if (cmd_tmo_on)  tmo_mode <= 1'b1;
    else if (cmd_tmo_off) tmo_mode <= 1'b0;
  end

  // Command decode uses the mode held before this edge.
  always_comb begin
    op = OP_NONE;
    if (cmd_tmo_on)
      op = OP_ARM;
    else if (tmo_mode) begin
      if (rx_xfer) op = OP_LOAD;
    end else begin
      if (cmd_start)     op = OP_LOAD;
      else if (cmd_stop) op = OP_HALT;
    end
  end
endmodule

// File: rtl/rxt_down_counter.sv
module rxt_down_counter
  import rxt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  rxt_op_e          op,
  input  logic [CNT_W-1:0] preload,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ready
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      ready   <= 1'b0;
      running <= 1'b0;
    end else begin
      unique case (op)
        OP_ARM, OP_HALT: begin
          running <= 1'b0;
          ready   <= 1'b0;
        end
        OP_LOAD: begin
          count   <= preload;
          running <= 1'b1;
        end
        default: begin
          if (running && tick) begin
            if (count == ONE) begin
              ready <= 1'b1;
              count <= preload;
            end else begin
              count <= count - ONE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rxt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] preload,
  input  logic             tick,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_tmo_on,
  input  logic             cmd_tmo_off,
  input  logic             rx_xfer,
  output logic             ready,
  output logic [CNT_W-1:0] count
);
  rxt_op_e op;
  logic    tmo_mode;

  rxt_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .cmd_tmo_on (cmd_tmo_on),
    .cmd_tmo_off(cmd_tmo_off),
    .rx_xfer    (rx_xfer),
    .op         (op),
    .tmo_mode   (tmo_mode)
  );

  rxt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .preload(preload),
    .tick   (tick),
    .count  (count),
    .ready  (ready)
  );

  // R5: arming always leaves the flag clear
  a_r5_arm_clears: assert property (@(posedge clk) disable iff (rst)
    cmd_tmo_on |=> !ready);

  // R7: a receive transfer in timeout mode loads the preload value
  a_r7_xfer_reload: assert property (@(posedge clk) disable iff (rst)
    (tmo_mode && rx_xfer && !cmd_tmo_on) |=> count == $past(preload));

  // R6: start is ignored while timeout mode is on
  a_r6_start_locked: assert property (@(posedge clk) disable iff (rst)
    (tmo_mode && cmd_start && !rx_xfer && !cmd_tmo_on && !tick)
      |=> $stable(count));

  // R8: leaving timeout mode keeps a pending flag
  a_r8_off_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    (cmd_tmo_off && !cmd_tmo_on && ready) |=> ready);

  // R4: a normal-mode stop clears the flag
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (!tmo_mode && cmd_stop && !cmd_start && !cmd_tmo_on) |=> !ready);

  // R3: the flag only rises on a tick that found the count at 1
  a_r3_expiry_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(tick) && $past(count) == CNT_W'(1)));
endmodule

// File: tb/rx_idle_timer_test.sv
module rx_idle_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] preload = '0;
  logic         tick = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic         cmd_tmo_on = 1'b0, cmd_tmo_off = 1'b0, rx_xfer = 1'b0;
  logic         ready;
  logic [W-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rx_idle_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .preload(preload), .tick(tick),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_tmo_on(cmd_tmo_on),
    .cmd_tmo_off(cmd_tmo_off), .rx_xfer(rx_xfer), .ready(ready), .count(count)
  );

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_pulse(int pv);
    preload = W'(pv); cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc();
    chk("R1 ready", int'(ready), 0);
    chk("R1 count", int'(count), 0);
    ticks(3);
    chk("R1 halted", int'(count), 0);
  endtask

  task automatic t_normal;
    start_pulse(5);
    chk("R2 load", int'(count), 5);
    ticks(3);
    chk("R2 decrement", int'(count), 2);
    ticks(1);
    chk("R2 reach 1", int'(count), 1);
    chk("R3 not yet", int'(ready), 0);
    ticks(1);
    chk("R3 ready set", int'(ready), 1);
    chk("R3 reload", int'(count), 5);
    ticks(1);
    chk("R3 keeps running", int'(count), 4);
    chk("R3 sticky", int'(ready), 1);
    cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
    chk("R4 stop clears", int'(ready), 0);
    ticks(3);
    chk("R4 halted", int'(count), 4);
    preload = W'(9); rx_xfer = 1'b1; cyc(); rx_xfer = 1'b0;
    chk("R7 xfer ignored normal", int'(count), 4);
    ticks(2);
    chk("R7 still halted", int'(count), 4);
  endtask

  task automatic t_timeout;
    start_pulse(3);
    ticks(3);
    chk("R3 expiry", int'(ready), 1);
    cmd_tmo_on = 1'b1; cyc(); cmd_tmo_on = 1'b0;
    chk("R5 arm clears", int'(ready), 0);
    ticks(4);
    chk("R5 idle", int'(count), 3);
    start_pulse(7);
    chk("R6 start ignored", int'(count), 3);
    ticks(1);
    chk("R6 still idle", int'(count), 3);
    rx_xfer = 1'b1; cyc(); rx_xfer = 1'b0;
    chk("R7 xfer reload", int'(count), 7);
    ticks(2);
    chk("R7 running", int'(count), 5);
    cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
    ticks(1);
    chk("R6 stop ignored", int'(count), 4);
    ticks(4);
    chk("R7 gap detected", int'(ready), 1);
    chk("R7 reload after expiry", int'(count), 7);
    rx_xfer = 1'b1; cyc(); rx_xfer = 1'b0;
    chk("R7 xfer keeps ready", int'(ready), 1);
    cmd_tmo_off = 1'b1; cyc(); cmd_tmo_off = 1'b0;
    chk("R8 off keeps ready", int'(ready), 1);
    ticks(1);
    chk("R8 off keeps running", int'(count), 6);
    cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
    chk("R9 stop clears", int'(ready), 0);
    ticks(2);
    chk("R9 stopped", int'(count), 6);
    start_pulse(2);
    chk("R8 start works again", int'(count), 2);
  endtask

  task automatic t_priority;
    preload = W'(11); cmd_start = 1'b1; tick = 1'b1; cyc();
    cmd_start = 1'b0; tick = 1'b0;
    chk("R10 load over tick", int'(count), 11);
    preload = W'(20); cmd_start = 1'b1; cmd_stop = 1'b1; cyc();
    cmd_start = 1'b0; cmd_stop = 1'b0;
    ticks(1);
    chk("R10 load over stop", int'(count), 19);
    preload = W'(30); cmd_tmo_on = 1'b1; rx_xfer = 1'b1; cmd_start = 1'b1; cyc();
    cmd_tmo_on = 1'b0; rx_xfer = 1'b0; cmd_start = 1'b0;
    chk("R10 arm wins", int'(count), 19);
    cmd_tmo_off = 1'b1; cmd_start = 1'b1; cyc();
    cmd_tmo_off = 1'b0; cmd_start = 1'b0;
    chk("R10 old mode decodes", int'(count), 19);
    start_pulse(4);
    chk("R10 normal after off", int'(count), 4);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_timeout();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule